// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block keeps the program order of micro-operations in a processor core. A front end places up to three new micro-ops per cycle at the tail of a 40-slot ring. Each slot records the destination register, a completion flag, the result value and a fault flag. Execution units complete slots in any order by naming the slot index. Each slot stays in the ring from allocation until it commits, both while it waits to execute and after its result has arrived.

Every cycle a commit stage looks at the three oldest slots. It commits completed ones in program order into an eight-entry architectural register file and frees their slots. It stops at the first slot that has not completed. A completed slot that carries a fault (an exception, an interrupt taken at that point, or a mispredicted branch) is not committed. It raises a one-cycle flush that empties the whole ring and reports the index of the faulting slot. Older slots that commit in the same cycle still update the register file.

Top module: `rob_core`

## Requirements
- R1: After reset, occupancy is 0, alloc_base is 0, alloc_ready is 1, retire_cnt is 0, flush is 0, and all eight architectural registers read 0.
- R2: When alloc_ready is 1 and alloc_cnt (0 to 3) is non-zero, the new micro-ops take slots alloc_base, alloc_base+1 and so on. Lane j takes destination alloc_dest[3j+2:3j]. From the next cycle, alloc_base has moved forward by alloc_cnt and occupancy has grown by alloc_cnt minus the number committed.
- R3: alloc_ready is 0 exactly when fewer than three slots are free or flush is high in the same cycle. Micro-ops offered while it is 0 are not taken.
- R4: A write-back on port p (index wb_idx[6p+5:6p], data wb_data[32p+31:32p], fault bit wb_fault[p]) marks that slot complete and stores the data and the fault bit. It has no effect when the index is 40 or more, when the slot is not allocated, or when the slot is already complete.
- R5: In each cycle, retire_cnt counts how many of the oldest slots commit, at most three. Commit starts at the oldest slot, follows program order, and stops at the first slot that is not complete or is faulting.
- R6: At the end of the cycle in which a slot commits, its data is written into its destination register. When several slots commit to the same register in one cycle, the youngest one wins. rd_data shows register rd_addr in the same cycle.
- R7: When commit reaches a completed faulting slot, flush is 1 in that cycle and flush_idx gives that slot's index. That slot is not committed. In the next cycle occupancy is 0 and alloc_base is 0.
- R8: Slot indices wrap from 39 back to 0 for allocation, completion and commit.
- R9: Allocations and write-backs offered in a flush cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_cnt | input | 2 | Number of micro-ops offered this cycle (0 to 3) |
| alloc_dest | input | 9 | Destination register per allocation lane, 3 bits each, lane 0 in the low bits |
| alloc_ready | output | 1 | Offer is taken this cycle |
| alloc_base | output | 6 | Slot index given to allocation lane 0 |
| wb_valid | input | 2 | Write-back request per port |
| wb_idx | input | 12 | Slot index per port, 6 bits each |
| wb_data | input | 64 | Result per port, 32 bits each |
| wb_fault | input | 2 | Fault flag per port |
| retire_cnt | output | 2 | Slots committing this cycle |
| flush | output | 1 | Faulting slot reached; ring is emptied at this edge |
| flush_idx | output | 6 | Index of the faulting slot |
| occupancy | output | 6 | Number of allocated slots |
| rd_addr | input | 3 | Architectural register read address |
| rd_data | output | 32 | Architectural register read data |

## Verification
alloc_ready, alloc_base, occupancy, retire_cnt, flush and flush_idx are decoded from the registered ring state. They are read in the same cycle, one nanosecond after the falling edge at which the bench drives inputs. A write-back therefore shows up in retire_cnt one cycle after it is driven. A committed value shows up on rd_data one cycle after the cycle in which retire_cnt counted it. A flush empties the ring one cycle after flush is seen. The bench applies every input to its own model at the rising edge that follows the check. Each expectation is thus compared in the cycle after the stimulus, never in the cycle of the stimulus. Register sweeps step rd_addr several times inside one low clock phase.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    LANE_IDLE   = 2'd0,
    LANE_COMMIT = 2'd1,
    LANE_FAULT  = 2'd2,
    LANE_WAIT   = 2'd3
  } lane_state_e;

  // Advance a ring index; off must be smaller than depth.
  function automatic int unsigned ring_add(input int unsigned base,
                                           input int unsigned off,
                                           input int unsigned depth);
    int unsigned s;
    s = base + off;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  function automatic int unsigned ring_free(input int unsigned occ,
                                            input int unsigned depth);
    return depth - occ;
  endfunction

endpackage

// File: rtl/rob_entries.sv
module rob_entries
  import rob_pkg::*;
#(
  parameter int DEPTH    = 40,
  parameter int LANES    = 3,
  parameter int WB_PORTS = 2,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 3,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int ACW     = $clog2(LANES + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              head,
  input  logic [IDX_W-1:0]              tail,
  input  logic                          alloc_fire,
  input  logic [ACW-1:0]                alloc_cnt,
  input  logic [LANES*TAG_W-1:0]        alloc_dest,
  input  logic [WB_PORTS-1:0]           wb_valid,
  input  logic [WB_PORTS*IDX_W-1:0]     wb_idx,
  input  logic [WB_PORTS*DATA_W-1:0]    wb_data,
  input  logic [WB_PORTS-1:0]           wb_fault,
  input  logic [LANES-1:0]              lane_commit,
  input  logic                          flush,
  output logic [LANES-1:0][IDX_W-1:0]   lane_slot,
  output logic [LANES-1:0]              lane_done,
  output logic [LANES-1:0]              lane_fault,
  output logic [LANES-1:0][TAG_W-1:0]   lane_dest,
  output logic [LANES-1:0][DATA_W-1:0]  lane_data
);

  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  done_q;
  logic [DEPTH-1:0]  fault_q;
  logic [TAG_W-1:0]  dest_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  logic [LANES-1:0][IDX_W-1:0] alloc_slot;
  logic [IDX_W-1:0]            wb_i     [WB_PORTS];
  logic [WB_PORTS-1:0]         wb_in_range;
  logic [WB_PORTS-1:0]         wb_hit;

  // Slot indices for the commit window and the allocation window
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      lane_slot[k]  = IDX_W'(ring_add(32'(head), k, DEPTH));
      alloc_slot[k] = IDX_W'(ring_add(32'(tail), k, DEPTH));
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      lane_done[k]  = done_q[lane_slot[k]];
      lane_fault[k] = fault_q[lane_slot[k]];
      lane_dest[k]  = dest_q[lane_slot[k]];
      lane_data[k]  = data_q[lane_slot[k]];
    end
  end

  // Write-back decode: only a live, not yet completed slot accepts a result
  always_comb begin
    for (int p = 0; p < WB_PORTS; p++) begin
      wb_i[p]        = wb_idx[p*IDX_W +: IDX_W];
      wb_in_range[p] = int'(wb_i[p]) < DEPTH;
      wb_hit[p]      = wb_valid[p] && wb_in_range[p] && !flush &&
                       (wb_in_range[p] ? (valid_q[wb_i[p]] && !done_q[wb_i[p]]) : 1'b0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      done_q  <= '0;
      fault_q <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        dest_q[e] <= '0;
        data_q[e] <= '0;
      end
    end else if (flush) begin
      valid_q <= '0;
      done_q  <= '0;
      fault_q <= '0;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (lane_commit[k]) begin
          valid_q[lane_slot[k]] <= 1'b0;
          done_q[lane_slot[k]]  <= 1'b0;
        end
      end
      for (int p = 0; p < WB_PORTS; p++) begin
        if (wb_hit[p]) begin
          done_q[wb_i[p]]  <= 1'b1;
          fault_q[wb_i[p]] <= wb_fault[p];
          data_q[wb_i[p]]  <= wb_data[p*DATA_W +: DATA_W];
        end
      end
      for (int k = 0; k < LANES; k++) begin
        if (alloc_fire && (k < int'(alloc_cnt))) begin
          valid_q[alloc_slot[k]] <= 1'b1;
          done_q[alloc_slot[k]]  <= 1'b0;
          fault_q[alloc_slot[k]] <= 1'b0;
          dest_q[alloc_slot[k]]  <= alloc_dest[k*TAG_W +: TAG_W];
        end
      end
    end
  end

  generate
    for (genvar p = 0; p < WB_PORTS; p++) begin : g_wb_chk
      AST_WB_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid[p] && wb_in_range[p] && done_q[wb_i[p]])
        |=> (data_q[$past(wb_i[p])] == $past(data_q[wb_i[p]]))); // R4
    end
  endgenerate

endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DEPTH  = 40,
  parameter int LANES  = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int ACW   = $clog2(LANES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CNT_W-1:0]            occ,
  input  logic [LANES-1:0][IDX_W-1:0] lane_slot,
  input  logic [LANES-1:0]            lane_done,
  input  logic [LANES-1:0]            lane_fault,
  output logic [LANES-1:0]            lane_commit,
  output logic [ACW-1:0]              commit_cnt,
  output logic                        flush,
  output logic [IDX_W-1:0]            flush_idx
);

  lane_state_e lane_st [LANES];
  logic        blocked;

  // Walk the oldest slots in order; the first non-committable one ends the walk
  always_comb begin
    blocked = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      lane_st[k] = LANE_IDLE;
      if (!blocked) begin
        if (k >= int'(occ)) begin
          blocked = 1'b1;
        end else if (!lane_done[k]) begin
          lane_st[k] = LANE_WAIT;
          blocked    = 1'b1;
        end else if (lane_fault[k]) begin
          lane_st[k] = LANE_FAULT;
          blocked    = 1'b1;
        end else begin
          lane_st[k] = LANE_COMMIT;
        end
      end
    end
  end

  always_comb begin
    commit_cnt = '0;
    flush      = 1'b0;
    flush_idx  = '0;
    for (int k = 0; k < LANES; k++) begin
      lane_commit[k] = (lane_st[k] == LANE_COMMIT);
      if (lane_commit[k]) commit_cnt = commit_cnt + ACW'(1);
      if (lane_st[k] == LANE_FAULT) begin
        flush     = 1'b1;
        flush_idx = lane_slot[k];
      end
    end
  end

  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (((lane_commit + LANES'(1)) & lane_commit) == '0)); // R5

endmodule

// File: rtl/rob_arf.sv
module rob_arf #(
  parameter int NREG   = 8,
  parameter int DATA_W = 32,
  parameter int LANES  = 3,
  localparam int TAG_W = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             lane_commit,
  input  logic [LANES-1:0][TAG_W-1:0]  lane_dest,
  input  logic [LANES-1:0][DATA_W-1:0] lane_data,
  input  logic [TAG_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]            rd_data
);

  logic [DATA_W-1:0] regs_q [NREG];

  // Lanes are applied oldest first so the youngest write to a register wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (lane_commit[k]) regs_q[lane_dest[k]] <= lane_data[k];
      end
    end
  end

  assign rd_data = regs_q[rd_addr];

endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH    = 40,
  parameter int LANES    = 3,
  parameter int WB_PORTS = 2,
  parameter int DATA_W   = 32,
  parameter int NREG     = 8,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int TAG_W   = $clog2(NREG),
  localparam int ACW     = $clog2(LANES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ACW-1:0]             alloc_cnt,
  input  logic [LANES*TAG_W-1:0]     alloc_dest,
  output logic                       alloc_ready,
  output logic [IDX_W-1:0]           alloc_base,
  input  logic [WB_PORTS-1:0]        wb_valid,
  input  logic [WB_PORTS*IDX_W-1:0]  wb_idx,
  input  logic [WB_PORTS*DATA_W-1:0] wb_data,
  input  logic [WB_PORTS-1:0]        wb_fault,
  output logic [ACW-1:0]             retire_cnt,
  output logic                       flush,
  output logic [IDX_W-1:0]           flush_idx,
  output logic [CNT_W-1:0]           occupancy,
  input  logic [TAG_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]          rd_data
);

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] occ_q;

  logic                        alloc_fire;
  logic [ACW-1:0]              alloc_take;
  logic [ACW-1:0]              commit_cnt;
  logic                        flush_now;
  logic [IDX_W-1:0]            flush_slot;
  logic [LANES-1:0]            lane_commit;
  logic [LANES-1:0][IDX_W-1:0] lane_slot;
  logic [LANES-1:0]            lane_done;
  logic [LANES-1:0]            lane_fault;
  logic [LANES-1:0][TAG_W-1:0] lane_dest;
  logic [LANES-1:0][DATA_W-1:0] lane_data;

  assign alloc_ready = (ring_free(32'(occ_q), DEPTH) >= LANES) && !flush_now;
  assign alloc_fire  = alloc_ready && (alloc_cnt != '0);
  assign alloc_take  = alloc_fire ? alloc_cnt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else if (flush_now) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= IDX_W'(ring_add(32'(head_q), 32'(commit_cnt), DEPTH));
      tail_q <= IDX_W'(ring_add(32'(tail_q), 32'(alloc_take), DEPTH));
      occ_q  <= occ_q - CNT_W'(commit_cnt) + CNT_W'(alloc_take);
    end
  end

  rob_entries #(
    .DEPTH(DEPTH), .LANES(LANES), .WB_PORTS(WB_PORTS),
    .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_entries (
    .clk(clk), .rst_n(rst_n),
    .head(head_q), .tail(tail_q),
    .alloc_fire(alloc_fire), .alloc_cnt(alloc_cnt), .alloc_dest(alloc_dest),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .wb_fault(wb_fault),
    .lane_commit(lane_commit), .flush(flush_now),
    .lane_slot(lane_slot), .lane_done(lane_done), .lane_fault(lane_fault),
    .lane_dest(lane_dest), .lane_data(lane_data)
  );

  rob_retire #(.DEPTH(DEPTH), .LANES(LANES)) u_retire (
    .clk(clk), .rst_n(rst_n),
    .occ(occ_q), .lane_slot(lane_slot),
    .lane_done(lane_done), .lane_fault(lane_fault),
    .lane_commit(lane_commit), .commit_cnt(commit_cnt),
    .flush(flush_now), .flush_idx(flush_slot)
  );

  rob_arf #(.NREG(NREG), .DATA_W(DATA_W), .LANES(LANES)) u_arf (
    .clk(clk), .rst_n(rst_n),
    .lane_commit(lane_commit), .lane_dest(lane_dest), .lane_data(lane_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign alloc_base = tail_q;
  assign retire_cnt = commit_cnt;
  assign flush      = flush_now;
  assign flush_idx  = flush_slot;
  assign occupancy  = occ_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> (int'(occ_q) + int'(alloc_cnt) <= DEPTH)); // R3

  AST_READY_LOW_WHEN_TIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ_q) > DEPTH - LANES) |-> !alloc_ready); // R3

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> (occ_q == '0 && tail_q == '0)); // R7

  AST_OCC_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_now |=> (int'(occ_q) == int'($past(occ_q)) + int'($past(alloc_take))
                                   - int'($past(commit_cnt)))); // R2

endmodule

// File: tb/sim_rob_core.sv
`timescale 1ns/100ps
module sim_rob_core;
  localparam int DEPTH = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  alloc_cnt = '0;
  logic [8:0]  alloc_dest = '0;
  logic [1:0]  wb_valid = '0;
  logic [11:0] wb_idx = '0;
  logic [63:0] wb_data = '0;
  logic [1:0]  wb_fault = '0;
  logic [2:0]  rd_addr = '0;
  logic        alloc_ready, flush;
  logic [5:0]  alloc_base, flush_idx, occupancy;
  logic [1:0]  retire_cnt;
  logic [31:0] rd_data;

  always #4 clk = ~clk;

  rob_core u0 (
    .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .alloc_dest(alloc_dest),
    .alloc_ready(alloc_ready), .alloc_base(alloc_base), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data), .wb_fault(wb_fault),
    .retire_cnt(retire_cnt), .flush(flush), .flush_idx(flush_idx),
    .occupancy(occupancy), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  // Reference model state
  bit          m_valid [DEPTH];
  bit          m_done  [DEPTH];
  bit          m_fault [DEPTH];
  int          m_dest  [DEPTH];
  logic [31:0] m_data  [DEPTH];
  logic [31:0] arch    [8];
  int m_head = 0, m_tail = 0, m_occ = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Oldest-first walk: count commits, detect a fault at the frontier
  function automatic void model_retire(output int n, output bit fl, output int fi);
    n = 0; fl = 0; fi = 0;
    for (int k = 0; k < 3; k++) begin
      int e;
      if (k >= m_occ) break;
      e = (m_head + k) % DEPTH;
      if (!m_done[e]) break;
      if (m_fault[e]) begin fl = 1; fi = e; break; end
      n++;
    end
  endfunction

  function automatic int pending(input int nth);
    for (int k = 0; k < m_occ; k++) begin
      int e;
      e = (m_head + k) % DEPTH;
      if (!m_done[e]) begin
        if (nth == 0) return e;
        nth--;
      end
    end
    return -1;
  endfunction

  task automatic step(input int ac, input logic [8:0] dests, input logic [1:0] wv,
                      input logic [11:0] wi, input logic [63:0] wd, input logic [1:0] wf,
                      input bit sweep, input string tg);
    int n, fi; bit fl, rdy;
    @(negedge clk);
    alloc_cnt = 2'(ac); alloc_dest = dests;
    wb_valid = wv; wb_idx = wi; wb_data = wd; wb_fault = wf;
    rd_addr = 3'(cyc % 8);
    #1;
    model_retire(n, fl, fi);
    rdy = ((DEPTH - m_occ) >= 3) && !fl;
    chk("R3", alloc_ready, rdy);
    chk((m_tail < 3) ? "R8" : "R2", alloc_base, m_tail);
    chk("R2", occupancy, m_occ);
    chk("R5", retire_cnt, n);
    chk("R7", flush, fl);
    if (fl) chk("R7", flush_idx, fi);
    chk("R6", rd_data, arch[rd_addr]);
    if (sweep) begin
      for (int r = 0; r < 8; r++) begin
        rd_addr = 3'(r);
        #0.3;
        chk(tg, rd_data, arch[r]);
      end
    end
    // Apply this cycle to the model, as of the next rising edge
    for (int k = 0; k < n; k++) begin
      int e;
      e = (m_head + k) % DEPTH;
      arch[m_dest[e]] = m_data[e];
      m_valid[e] = 0; m_done[e] = 0;
    end
    if (fl) begin
      for (int e = 0; e < DEPTH; e++) begin m_valid[e] = 0; m_done[e] = 0; m_fault[e] = 0; end
      m_head = 0; m_tail = 0; m_occ = 0;
    end else begin
      m_head = (m_head + n) % DEPTH;
      for (int p = 0; p < 2; p++) begin
        int e;
        e = int'(wi[p*6 +: 6]);
        if (wv[p] && e < DEPTH && m_valid[e] && !m_done[e]) begin
          m_done[e] = 1; m_fault[e] = wf[p]; m_data[e] = wd[p*32 +: 32];
        end
      end
      if (rdy && ac > 0) begin
        for (int k = 0; k < ac; k++) begin
          int e;
          e = (m_tail + k) % DEPTH;
          m_valid[e] = 1; m_done[e] = 0; m_fault[e] = 0; m_dest[e] = int'(dests[k*3 +: 3]);
        end
        m_tail = (m_tail + ac) % DEPTH;
        m_occ  = m_occ + ac;
      end
      m_occ = m_occ - n;
    end
    cyc++;
  endtask

  task automatic idle(input bit sweep, input string tg);
    step(0, '0, '0, '0, '0, '0, sweep, tg);
  endtask

  task automatic wb_two(input int e0, input int e1, input bit f1);
    logic [1:0] v; logic [11:0] i; logic [63:0] d; logic [1:0] f;
    v = '0; i = '0; f = '0;
    d = {$urandom(), $urandom()};
    if (e0 >= 0) begin v[0] = 1; i[5:0] = 6'(e0); end
    if (e1 >= 0 && e1 != e0) begin v[1] = 1; i[11:6] = 6'(e1); f[1] = f1; end
    step(0, '0, v, i, d, f, 0, "");
  endtask

  task automatic drain();
    for (int g = 0; g < 100 && m_occ > 0; g++) wb_two(pending(0), pending(1), 0);
    idle(0, ""); idle(0, "");
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int e = 0; e < DEPTH; e++) begin
      m_valid[e] = 0; m_done[e] = 0; m_fault[e] = 0; m_dest[e] = 0; m_data[e] = '0;
    end
    for (int r = 0; r < 8; r++) arch[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", occupancy, 0);
    chk("R1", alloc_base, 0);
    chk("R1", alloc_ready, 1);
    chk("R1", retire_cnt, 0);
    chk("R1", flush, 0);
    idle(1, "R1");

    // R3: fill until fewer than three slots remain, then offer more
    for (int j = 0; j < 15; j++) step(3, 9'($urandom()), '0, '0, '0, '0, 0, "");
    // R4: out-of-order completion, head still pending -> nothing retires
    step(0, '0, 2'b01, {6'd0, 6'd2}, {32'd0, 32'h1111_2222}, '0, 0, "");
    // R4: out-of-range index and overwrite of a completed slot are ignored
    step(0, '0, 2'b11, {6'd2, 6'd45}, {32'hdead_beef, 32'h5555_6666}, '0, 0, "");
    // R5: complete the two oldest -> three commit next cycle
    step(0, '0, 2'b11, {6'd1, 6'd0}, {32'hb0b0_0001, 32'ha0a0_0000}, '0, 0, "");
    idle(1, "R6");
    drain();

    // R6: three commits to one register in one cycle, youngest wins
    step(3, {3'd5, 3'd5, 3'd5}, '0, '0, '0, '0, 0, "");
    wb_two(pending(0), pending(1), 0);
    wb_two(pending(0), -1, 0);
    idle(0, ""); idle(1, "R6");

    // R7/R9: middle slot faults; offers in the flush cycle are discarded
    step(3, 9'($urandom()), '0, '0, '0, '0, 0, "");
    wb_two(pending(0), pending(1), 1);
    step(3, 9'($urandom()), 2'b01, {6'd0, 6'(pending(0))}, {32'd0, 32'h7777_0000}, '0, 0, "");
    idle(1, "R9");

    // Random traffic, wrapping the ring many times (R8)
    for (int j = 0; j < 3000; j++) begin
      logic [1:0] v; logic [11:0] i; logic [63:0] d; logic [1:0] f;
      v = '0; i = '0; f = '0;
      d = {$urandom(), $urandom()};
      for (int p = 0; p < 2; p++) begin
        int r, e;
        r = int'($urandom() % 10);
        if (r < 7) e = pending(int'($urandom() % 3));
        else if (r < 9) e = (m_head + int'($urandom() % DEPTH)) % DEPTH;
        else e = DEPTH + int'($urandom() % 24);
        if (e >= 0 && !(p == 1 && v[0] && int'(i[5:0]) == e)) begin
          v[p] = 1; i[p*6 +: 6] = 6'(e); f[p] = ($urandom() % 60) == 0;
        end
      end
      step(int'($urandom() % 4), 9'($urandom()), v, i, d, f, (j % 97) == 0, "R6");
    end
    drain();
    idle(1, "R6");

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule